// File: doc/BRIEF.md
# Multi-Wide Register Rename Unit

This block renames a group of up to `LANES` instructions in one cycle. Each lane carries two architectural source register numbers and, optionally, one architectural destination. Lane 0 is the oldest instruction in the group and the highest lane is the youngest. The unit looks up the current physical mapping of every source and destination in an alias table. Every lane that writes a register gets a fresh physical tag from a free-tag queue. Sources that read a register produced earlier in the same group are then repaired to use that producer's fresh tag.

An all-pairs comparison of each source against every older destination in the group finds the closest older producer. The alias table is updated so that only the youngest writer of each architectural register leaves its tag behind. The results are registered and appear one cycle after the group is accepted. For each lane they are the physical source tags, the new destination tag and the mapping that destination replaced. Retirement returns freed tags through a one-per-cycle push port.

A group is accepted only as a whole. It is held off when the free queue has fewer tags than the group has writers.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register r maps to physical tag r. The free queue holds tags ARCH_REGS to PHYS_REGS-1 in ascending order. `ren_valid` is low, and `grp_ready` is high for any group.
- R2: A group is accepted on a rising edge where `grp_valid` and `grp_ready` are both high. Its results are presented with `ren_valid` high for exactly the next cycle, and `ren_lane_vld` echoes the accepted lane mask.
- R3: A source with no older writer of the same register in the group gets the alias-table tag, which reflects all previously accepted groups.
- R4: A source whose register is written by an older lane of the same group gets that lane's new tag. When several older lanes write the register, the closest older one wins.
- R5: A lane writes only when both its `grp_lane_vld` and `grp_has_dst` bits are 1. A lane that does not write allocates no tag, redirects no younger source, and leaves the alias table unchanged.
- R6: New tags go to writing lanes in ascending lane order, taken from the head of the free queue in FIFO order. A lane that does not write reports a destination tag of 0.
- R7: After a group, every register it wrote maps to the tag of its youngest writer in that group.
- R8: `ren_prev_tag` of a writing lane is the new tag of the closest older same-group writer of the same register, or the alias-table tag if there is none. Non-writing lanes report 0.
- R9: `grp_ready` is low exactly when the free queue holds fewer tags than the presented group has writers. A group offered while `grp_ready` is low allocates nothing, changes no mapping and produces no `ren_valid`.
- R10: A tag pushed on `retire_push` joins the tail of the free queue and is handed out after every tag already in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_valid | input | 1 | A rename group is offered |
| grp_ready | output | 1 | Enough free tags for the offered group |
| grp_lane_vld | input | LANES | Lane holds an instruction |
| grp_has_dst | input | LANES | Lane writes a destination register |
| grp_src_a | input | LANES*AW | First source register number per lane |
| grp_src_b | input | LANES*AW | Second source register number per lane |
| grp_dst | input | LANES*AW | Destination register number per lane |
| ren_valid | output | 1 | Rename results present |
| ren_lane_vld | output | LANES | Lane mask of the renamed group |
| ren_src_a_tag | output | LANES*TW | Physical tag of the first source |
| ren_src_b_tag | output | LANES*TW | Physical tag of the second source |
| ren_dst_tag | output | LANES*TW | Newly allocated destination tag |
| ren_prev_tag | output | LANES*TW | Tag the destination mapped to before |
| retire_push | input | 1 | Return one tag to the free queue |
| retire_tag | input | TW | Tag being returned |

## Verification
The bench offers the dependent three-instruction sequence: a writer of r1, a reader of r1, and a second writer of r1. A design that skipped the same-group repair would hand the reader a stale tag. One that let the older writer win the alias-table update would leave r1 pointing at the wrong tag in the next group. Four writers of one register chained through their own sources catch a priority encoder that picks the oldest match rather than the nearest, and a wrong previous-mapping chain. Further cases cover lanes that are invalid or carry no destination yet share a register with younger readers, and draining the free queue to one tag and then to zero. These catch an off-by-one ready comparison, allocation on a stalled group, and returned tags that come out of order.

// File: rtl/rename_pkg.sv
package rename_pkg;

   // true when v is a nonzero power of two
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // index width that stays at least one bit wide
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rename_free_fifo.sv
module rename_free_fifo
   import rename_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter int TW         = 6,
   parameter int POPS       = 4,
   parameter int INIT_BASE  = 32,
   parameter int INIT_COUNT = 32,
   localparam int PTRW      = $clog2(DEPTH),
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int NW        = $clog2(POPS + 1),
   localparam int PEEKN     = 2 ** idx_width(POPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NW-1:0]            pop_num,
   input  logic                     push,
   input  logic [TW-1:0]            push_tag,
   output logic [PEEKN-1:0][TW-1:0] peek,
   output logic [CW-1:0]            count
);

   logic [TW-1:0]   mem [DEPTH];
   logic [PTRW-1:0] head;
   logic [PTRW-1:0] tail;

   always_comb begin
      for (int k = 0; k < PEEKN; k++) begin
         peek[k] = mem[head + PTRW'(k)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            mem[k] <= (k < INIT_COUNT) ? TW'(INIT_BASE + k) : '0;
         end
         head  <= '0;
         tail  <= PTRW'(INIT_COUNT);
         count <= CW'(INIT_COUNT);
      end else begin
         head  <= head + PTRW'(pop_num);
         count <= count + CW'(push) - CW'(pop_num);
         if (push) begin
            mem[tail] <= push_tag;
            tail      <= tail + PTRW'(1);
         end
      end
   end

endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
   parameter int ARCH_REGS = 32,
   parameter int TW        = 6,
   parameter int LANES     = 4,
   localparam int AW       = $clog2(ARCH_REGS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANES-1:0][AW-1:0] rd_a,
   input  logic [LANES-1:0][AW-1:0] rd_b,
   input  logic [LANES-1:0][AW-1:0] rd_d,
   output logic [LANES-1:0][TW-1:0] map_a,
   output logic [LANES-1:0][TW-1:0] map_b,
   output logic [LANES-1:0][TW-1:0] map_d,
   input  logic [LANES-1:0]         wr_en,
   input  logic [LANES-1:0][AW-1:0] wr_arch,
   input  logic [LANES-1:0][TW-1:0] wr_tag
);

   logic [TW-1:0] table_q [ARCH_REGS];

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         map_a[i] = table_q[rd_a[i]];
         map_b[i] = table_q[rd_b[i]];
         map_d[i] = table_q[rd_d[i]];
      end
   end

   // enables arrive merged: at most one lane per register is set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ARCH_REGS; r++) begin
            table_q[r] <= TW'(r);
         end
      end else begin
         for (int i = 0; i < LANES; i++) begin
            if (wr_en[i]) begin
               table_q[wr_arch[i]] <= wr_tag[i];
            end
         end
      end
   end

endmodule

// File: rtl/rename_dep_check.sv
module rename_dep_check #(
   parameter int LANES = 4,
   parameter int AW    = 5,
   parameter int TW    = 6
) (
   input  logic [LANES-1:0]         writes,
   input  logic [LANES-1:0][AW-1:0] src_a,
   input  logic [LANES-1:0][AW-1:0] src_b,
   input  logic [LANES-1:0][AW-1:0] dst,
   input  logic [LANES-1:0][TW-1:0] new_tag,
   input  logic [LANES-1:0][TW-1:0] map_a,
   input  logic [LANES-1:0][TW-1:0] map_b,
   input  logic [LANES-1:0][TW-1:0] map_d,
   output logic [LANES-1:0][TW-1:0] phys_a,
   output logic [LANES-1:0][TW-1:0] phys_b,
   output logic [LANES-1:0][TW-1:0] prev_tag,
   output logic [LANES-1:0]         commit_en
);

   if (LANES == 1) begin : g_single
      // no older lane exists: tables pass straight through
      always_comb begin
         phys_a    = map_a;
         phys_b    = map_b;
         prev_tag  = writes[0] ? map_d : '0;
         commit_en = writes;
      end
   end else begin : g_multi
      // ascending scan: a later (closer older) match overrides
      always_comb begin
         for (int i = 0; i < LANES; i++) begin
            phys_a[i]   = map_a[i];
            phys_b[i]   = map_b[i];
            prev_tag[i] = map_d[i];
            for (int j = 0; j < i; j++) begin
               if (writes[j] && (dst[j] == src_a[i])) phys_a[i] = new_tag[j];
               if (writes[j] && (dst[j] == src_b[i])) phys_b[i] = new_tag[j];
               if (writes[j] && (dst[j] == dst[i]))   prev_tag[i] = new_tag[j];
            end
            if (!writes[i]) prev_tag[i] = '0;
         end
      end

      // a writer commits unless a younger lane writes the same register
      always_comb begin
         for (int i = 0; i < LANES; i++) begin
            commit_en[i] = writes[i];
            for (int j = i + 1; j < LANES; j++) begin
               if (writes[j] && (dst[j] == dst[i])) commit_en[i] = 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/rename_unit.sv
module rename_unit
   import rename_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int ARCH_REGS = 32,
   parameter int PHYS_REGS = 64,
   localparam int AW       = $clog2(ARCH_REGS),
   localparam int TW       = $clog2(PHYS_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                grp_valid,
   output logic                grp_ready,
   input  logic [LANES-1:0]    grp_lane_vld,
   input  logic [LANES-1:0]    grp_has_dst,
   input  logic [LANES*AW-1:0] grp_src_a,
   input  logic [LANES*AW-1:0] grp_src_b,
   input  logic [LANES*AW-1:0] grp_dst,
   output logic                ren_valid,
   output logic [LANES-1:0]    ren_lane_vld,
   output logic [LANES*TW-1:0] ren_src_a_tag,
   output logic [LANES*TW-1:0] ren_src_b_tag,
   output logic [LANES*TW-1:0] ren_dst_tag,
   output logic [LANES*TW-1:0] ren_prev_tag,
   input  logic                retire_push,
   input  logic [TW-1:0]       retire_tag
);

   localparam int CW    = $clog2(PHYS_REGS + 1);
   localparam int NW    = $clog2(LANES + 1);
   localparam int IW    = idx_width(LANES);
   localparam int PEEKN = 2 ** IW;
   localparam int SPARE = PHYS_REGS - ARCH_REGS;

   if (LANES < 1) begin : g_bad_lanes
      $error("rename_unit: LANES must be at least 1");
   end
   if (!is_pow2(ARCH_REGS) || !is_pow2(PHYS_REGS)) begin : g_bad_pow2
      $error("rename_unit: register counts must be powers of two");
   end
   if (SPARE < LANES) begin : g_bad_spare
      $error("rename_unit: need at least LANES spare physical registers");
   end

   logic [LANES-1:0][AW-1:0] src_a_v, src_b_v, dst_v;
   logic [LANES-1:0][TW-1:0] map_a, map_b, map_d;
   logic [LANES-1:0][TW-1:0] new_tag, phys_a, phys_b, prev_tag;
   logic [LANES-1:0][TW-1:0] dst_out;
   logic [LANES-1:0]         writes, commit_en, rat_we;
   logic [PEEKN-1:0][TW-1:0] peek;
   logic [CW-1:0]            free_cnt;
   logic [NW-1:0]            need, pop_num;
   logic                     fire;

   assign src_a_v = grp_src_a;
   assign src_b_v = grp_src_b;
   assign dst_v   = grp_dst;

   assign writes    = grp_lane_vld & grp_has_dst;
   assign need      = NW'($countones(writes));
   assign grp_ready = (CW'(need) <= free_cnt);
   assign fire      = grp_valid && grp_ready;
   assign pop_num   = fire ? need : '0;
   assign rat_we    = fire ? commit_en : '0;

   // writers take consecutive queue slots in lane order
   always_comb begin
      logic [IW-1:0] slot;
      slot = '0;
      for (int i = 0; i < LANES; i++) begin
         new_tag[i] = peek[slot];
         if (writes[i]) slot = slot + IW'(1);
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         dst_out[i] = writes[i] ? new_tag[i] : '0;
      end
   end

   rename_free_fifo #(
      .DEPTH      (PHYS_REGS),
      .TW         (TW),
      .POPS       (LANES),
      .INIT_BASE  (ARCH_REGS),
      .INIT_COUNT (SPARE)
   ) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop_num  (pop_num),
      .push     (retire_push),
      .push_tag (retire_tag),
      .peek     (peek),
      .count    (free_cnt)
   );

   rename_alias_table #(
      .ARCH_REGS (ARCH_REGS),
      .TW        (TW),
      .LANES     (LANES)
   ) u_rat (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_a    (src_a_v),
      .rd_b    (src_b_v),
      .rd_d    (dst_v),
      .map_a   (map_a),
      .map_b   (map_b),
      .map_d   (map_d),
      .wr_en   (rat_we),
      .wr_arch (dst_v),
      .wr_tag  (new_tag)
   );

   rename_dep_check #(
      .LANES (LANES),
      .AW    (AW),
      .TW    (TW)
   ) u_dep (
      .writes    (writes),
      .src_a     (src_a_v),
      .src_b     (src_b_v),
      .dst       (dst_v),
      .new_tag   (new_tag),
      .map_a     (map_a),
      .map_b     (map_b),
      .map_d     (map_d),
      .phys_a    (phys_a),
      .phys_b    (phys_b),
      .prev_tag  (prev_tag),
      .commit_en (commit_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ren_valid     <= 1'b0;
         ren_lane_vld  <= '0;
         ren_src_a_tag <= '0;
         ren_src_b_tag <= '0;
         ren_dst_tag   <= '0;
         ren_prev_tag  <= '0;
      end else begin
         ren_valid <= fire;
         if (fire) begin
            ren_lane_vld  <= grp_lane_vld;
            ren_src_a_tag <= phys_a;
            ren_src_b_tag <= phys_b;
            ren_dst_tag   <= dst_out;
            ren_prev_tag  <= prev_tag;
         end
      end
   end

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
   parameter int LANES     = 4,
   parameter int ARCH_REGS = 32,
   parameter int PHYS_REGS = 64,
   localparam int AW       = $clog2(ARCH_REGS),
   localparam int TW       = $clog2(PHYS_REGS),
   localparam int CW       = $clog2(PHYS_REGS + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                grp_valid,
   input logic                grp_ready,
   input logic [LANES-1:0]    grp_lane_vld,
   input logic [LANES-1:0]    grp_has_dst,
   input logic [LANES*AW-1:0] grp_src_a,
   input logic [LANES*AW-1:0] grp_dst,
   input logic                ren_valid,
   input logic [LANES*TW-1:0] ren_src_a_tag,
   input logic [LANES*TW-1:0] ren_dst_tag,
   input logic [LANES*TW-1:0] ren_prev_tag,
   input logic [CW-1:0]       free_cnt
);

   logic [LANES-1:0] wr;
   assign wr = grp_lane_vld & grp_has_dst;

   AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      grp_valid && !grp_ready |=> !ren_valid); // R9

   AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ren_valid |-> $past(grp_valid && grp_ready)); // R2

   AST_FREE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= CW'(PHYS_REGS)); // R10

   for (genvar i = 0; i < LANES; i++) begin : g_pair_i
      for (genvar j = i + 1; j < LANES; j++) begin : g_pair_j
         AST_NEW_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
            ren_valid && $past(wr[i] && wr[j])
            |-> ren_dst_tag[i*TW +: TW] != ren_dst_tag[j*TW +: TW]); // R6
      end
   end

   for (genvar j = 1; j < LANES; j++) begin : g_near
      AST_NEAREST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         ren_valid && $past(wr[j-1] && (grp_src_a[j*AW +: AW] == grp_dst[(j-1)*AW +: AW]))
         |-> ren_src_a_tag[j*TW +: TW] == ren_dst_tag[(j-1)*TW +: TW]); // R4

      AST_PREV_FROM_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
         ren_valid && $past(wr[j] && wr[j-1] && (grp_dst[j*AW +: AW] == grp_dst[(j-1)*AW +: AW]))
         |-> ren_prev_tag[j*TW +: TW] == ren_dst_tag[(j-1)*TW +: TW]); // R8
   end

endmodule

bind rename_unit rename_unit_chk #(
   .LANES     (LANES),
   .ARCH_REGS (ARCH_REGS),
   .PHYS_REGS (PHYS_REGS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .grp_valid     (grp_valid),
   .grp_ready     (grp_ready),
   .grp_lane_vld  (grp_lane_vld),
   .grp_has_dst   (grp_has_dst),
   .grp_src_a     (grp_src_a),
   .grp_dst       (grp_dst),
   .ren_valid     (ren_valid),
   .ren_src_a_tag (ren_src_a_tag),
   .ren_dst_tag   (ren_dst_tag),
   .ren_prev_tag  (ren_prev_tag),
   .free_cnt      (free_cnt)
);

// File: tb/rename_unit_bench.sv
module rename_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int L  = 4;
   localparam int NA = 32;
   localparam int NP = 64;
   localparam int AW = 5;
   localparam int TW = 6;

   typedef struct packed {
      logic [3:0]  vld;
      logic [3:0]  den;
      logic [19:0] sa;
      logic [19:0] sb;
      logic [19:0] d;
   } vec_t;

   // lane fields written {lane3, lane2, lane1, lane0}; lane 0 is oldest
   localparam int NV = 6;
   localparam vec_t VT [NV] = '{
      // independent writers
      '{4'hF, 4'hF, {5'd7, 5'd5, 5'd3, 5'd1}, {5'd8, 5'd6, 5'd4, 5'd2}, {5'd13, 5'd12, 5'd11, 5'd10}},
      // r1=r2+r3 ; r5=r1+r1 ; r1=r6+r7 ; lane3 invalid
      '{4'h7, 4'hF, {5'd1, 5'd6, 5'd1, 5'd2}, {5'd1, 5'd7, 5'd1, 5'd3}, {5'd1, 5'd1, 5'd5, 5'd1}},
      // lanes 2,3 carry no destination; lane3 reads r1 and r20
      '{4'hF, 4'h3, {5'd1, 5'd2, 5'd10, 5'd1}, {5'd20, 5'd3, 5'd11, 5'd5}, {5'd9, 5'd1, 5'd20, 5'd0}},
      // four writers of r4 chained through their sources
      '{4'hF, 4'hF, {5'd4, 5'd9, 5'd4, 5'd4}, {5'd4, 5'd4, 5'd9, 5'd4}, {5'd4, 5'd4, 5'd4, 5'd4}},
      // two writers of r7, nearest must win for lane3
      '{4'hF, 4'hF, {5'd7, 5'd7, 5'd2, 5'd1}, {5'd8, 5'd8, 5'd2, 5'd1}, {5'd2, 5'd7, 5'd8, 5'd7}},
      // lane1 invalid writer of r3 must not shadow lane0
      '{4'hD, 4'h7, {5'd3, 5'd3, 5'd0, 5'd1}, {5'd4, 5'd3, 5'd0, 5'd2}, {5'd3, 5'd6, 5'd3, 5'd3}}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            grp_valid = 1'b0;
   logic            grp_ready;
   logic [L-1:0]    grp_lane_vld = '0;
   logic [L-1:0]    grp_has_dst = '0;
   logic [L*AW-1:0] grp_src_a = '0;
   logic [L*AW-1:0] grp_src_b = '0;
   logic [L*AW-1:0] grp_dst = '0;
   logic            ren_valid;
   logic [L-1:0]    ren_lane_vld;
   logic [L*TW-1:0] ren_src_a_tag, ren_src_b_tag, ren_dst_tag, ren_prev_tag;
   logic            retire_push = 1'b0;
   logic [TW-1:0]   retire_tag = '0;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   // reference state
   int rat_m [NA];
   int fl_m  [NP];
   int fh, ft, fc;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rename_unit #(.LANES(L), .ARCH_REGS(NA), .PHYS_REGS(NP)) u_rename_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .grp_valid     (grp_valid),
      .grp_ready     (grp_ready),
      .grp_lane_vld  (grp_lane_vld),
      .grp_has_dst   (grp_has_dst),
      .grp_src_a     (grp_src_a),
      .grp_src_b     (grp_src_b),
      .grp_dst       (grp_dst),
      .ren_valid     (ren_valid),
      .ren_lane_vld  (ren_lane_vld),
      .ren_src_a_tag (ren_src_a_tag),
      .ren_src_b_tag (ren_src_b_tag),
      .ren_dst_tag   (ren_dst_tag),
      .ren_prev_tag  (ren_prev_tag),
      .retire_push   (retire_push),
      .retire_tag    (retire_tag)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_group(input logic [3:0] vld, input logic [3:0] den,
                            input logic [19:0] sa, input logic [19:0] sb,
                            input logic [19:0] d, input string name);
      logic [3:0] wr;
      int need, k;
      bit exp_ready;
      int nt [L];
      int ea [L];
      int eb [L];
      int ed [L];
      int ep [L];
      @(negedge clk);
      grp_valid    = 1'b1;
      grp_lane_vld = vld;
      grp_has_dst  = den;
      grp_src_a    = sa;
      grp_src_b    = sb;
      grp_dst      = d;
      wr   = vld & den;
      need = $countones(wr);
      exp_ready = (need <= fc);
      #1;
      check(grp_ready == exp_ready, "R9", {name, " ready"}, int'(grp_ready), int'(exp_ready));
      k = 0;
      for (int i = 0; i < L; i++) begin
         nt[i] = 0;
         if (wr[i]) begin
            nt[i] = fl_m[(fh + k) % NP];
            k++;
         end
      end
      for (int i = 0; i < L; i++) begin
         ea[i] = rat_m[sa[i*AW +: AW]];
         eb[i] = rat_m[sb[i*AW +: AW]];
         ep[i] = rat_m[d[i*AW +: AW]];
         for (int j = 0; j < i; j++) begin
            if (wr[j] && d[j*AW +: AW] == sa[i*AW +: AW]) ea[i] = nt[j];
            if (wr[j] && d[j*AW +: AW] == sb[i*AW +: AW]) eb[i] = nt[j];
            if (wr[j] && d[j*AW +: AW] == d[i*AW +: AW])  ep[i] = nt[j];
         end
         ed[i] = wr[i] ? nt[i] : 0;
         if (!wr[i]) ep[i] = 0;
      end
      @(negedge clk);
      grp_valid = 1'b0;
      check(ren_valid == exp_ready, "R2", {name, " ren_valid"}, int'(ren_valid), int'(exp_ready));
      if (exp_ready) begin
         check(ren_lane_vld == vld, "R2", {name, " lane mask"}, int'(ren_lane_vld), int'(vld));
         for (int i = 0; i < L; i++) begin
            if (vld[i]) begin
               check(int'(ren_src_a_tag[i*TW +: TW]) == ea[i], "R3/R4", {name, " src_a"},
                     int'(ren_src_a_tag[i*TW +: TW]), ea[i]);
               check(int'(ren_src_b_tag[i*TW +: TW]) == eb[i], "R3/R4", {name, " src_b"},
                     int'(ren_src_b_tag[i*TW +: TW]), eb[i]);
            end
            check(int'(ren_dst_tag[i*TW +: TW]) == ed[i], "R6", {name, " dst tag"},
                  int'(ren_dst_tag[i*TW +: TW]), ed[i]);
            check(int'(ren_prev_tag[i*TW +: TW]) == ep[i], "R8", {name, " prev tag"},
                  int'(ren_prev_tag[i*TW +: TW]), ep[i]);
         end
         // youngest writer wins (R7) and non-writers leave mapping alone (R5)
         for (int i = 0; i < L; i++) begin
            if (wr[i]) rat_m[d[i*AW +: AW]] = nt[i];
         end
         fh = (fh + need) % NP;
         fc = fc - need;
      end
   endtask

   task automatic push_tag(input int t);
      @(negedge clk);
      retire_push = 1'b1;
      retire_tag  = TW'(t);
      @(negedge clk);
      retire_push = 1'b0;
      fl_m[ft] = t;
      ft = (ft + 1) % NP;
      fc++;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NA; r++) rat_m[r] = r;
      for (int k = 0; k < NP; k++) fl_m[k] = (k < NP - NA) ? NA + k : 0;
      fh = 0;
      ft = NP - NA;
      fc = NP - NA;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(ren_valid == 1'b0, "R1", "ren_valid after reset", int'(ren_valid), 0);
      grp_lane_vld = 4'hF;
      grp_has_dst  = 4'hF;
      #1;
      check(grp_ready == 1'b1, "R1", "ready after reset", int'(grp_ready), 1);
      grp_lane_vld = '0;
      grp_has_dst  = '0;

      // R1 identity mapping and first tags (first vector reads reset table)
      for (int v = 0; v < NV; v++) begin
         run_group(VT[v].vld, VT[v].den, VT[v].sa, VT[v].sb, VT[v].d, $sformatf("vec%0d", v));
      end

      // R7: r1 must resolve to the younger writer of vec1, r4 to last of vec3
      run_group(4'h3, 4'h0, {5'd0, 5'd0, 5'd4, 5'd1}, {5'd0, 5'd0, 5'd7, 5'd5},
                {5'd0, 5'd0, 5'd0, 5'd0}, "R7 readback");

      // drain the free queue
      while (fc >= L) begin
         run_group(4'hF, 4'hF, {5'd3, 5'd2, 5'd1, 5'd0}, {5'd3, 5'd2, 5'd1, 5'd0},
                   {5'd17, 5'd16, 5'd15, 5'd14}, "drain");
      end
      // R9: too few tags stalls the whole group
      run_group(4'hF, 4'hF, {5'd14, 5'd14, 5'd14, 5'd14}, {5'd15, 5'd15, 5'd15, 5'd15},
                {5'd21, 5'd22, 5'd23, 5'd24}, "R9 stall full");
      run_group(4'hF, 4'((1 << fc) - 1), {5'd14, 5'd15, 5'd16, 5'd17},
                {5'd14, 5'd14, 5'd14, 5'd14}, {5'd25, 5'd26, 5'd27, 5'd28}, "R9 exact fit");
      check(fc == 0, "R9", "model queue empty", fc, 0);
      run_group(4'hF, 4'h0, {5'd25, 5'd26, 5'd27, 5'd28}, {5'd24, 5'd23, 5'd22, 5'd21},
                {5'd1, 5'd1, 5'd1, 5'd1}, "R5 no writers on empty queue");
      run_group(4'h1, 4'h1, {5'd0, 5'd0, 5'd0, 5'd2}, {5'd0, 5'd0, 5'd0, 5'd3},
                {5'd0, 5'd0, 5'd0, 5'd30}, "R9 stall one writer");

      // R10: returned tags come out in push order
      push_tag(40);
      push_tag(2);
      push_tag(17);
      run_group(4'hF, 4'hF, {5'd1, 5'd1, 5'd1, 5'd1}, {5'd1, 5'd1, 5'd1, 5'd1},
                {5'd8, 5'd7, 5'd6, 5'd5}, "R10 stall four");
      run_group(4'hF, 4'hB, {5'd30, 5'd6, 5'd30, 5'd1}, {5'd30, 5'd1, 5'd2, 5'd30},
                {5'd31, 5'd0, 5'd31, 5'd30}, "R10 refill order");
      run_group(4'h1, 4'h1, {5'd0, 5'd0, 5'd0, 5'd31}, {5'd0, 5'd0, 5'd0, 5'd30},
                {5'd0, 5'd0, 5'd0, 5'd31}, "R10 empty again");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule